// File: doc/BRIEF.md
# Rank-Ordered Per-Bank Request Scheduler

This block sits at the front of a shared memory controller. Requests from many threads arrive one per cycle. Each request names a thread and a target bank. It is stored in a buffer that belongs to that bank. Every bank has its own scheduler. Whenever a bank is idle and its buffer is not empty, it starts serving one request, and all banks do this in parallel. Each service holds the bank for a fixed, programmable number of cycles. Row state, refresh and command-bus timing are not modelled.

In ranked mode, every bank uses the same thread priority list, which arrives on an input port. A bank picks a request from the highest-ranked thread present in its buffer, and the oldest one when that thread has several. In arrival mode, a bank serves its buffer strictly oldest first. The block keeps a count of outstanding requests for each thread. A thread is stalled while its count is non-zero. When the thread's last request in any bank finishes, the block raises a one-cycle done pulse together with the current cycle number. The priority list is taken from the port only in cycles where no bank is serving, so it cannot change while a service is in flight.

Top module: `rank_bank_sched`

## Requirements
- R1: A request with `req_valid` high is accepted into the buffer of bank `req_bank` when `req_ready` is high. `req_ready` is low exactly when that bank's buffer already holds `QDEPTH` entries (or when `req_bank` is not a valid bank). A refused request is not stored and is never issued.
- R2: Every bank that is not busy and holds at least one entry raises its `issue_valid` bit in that same cycle, independently of the other banks.
- R3: In ranked mode (`arrival_order` = 0), the issued entry belongs to the thread with the smallest position in the ranking. Position p of the ranking is `rank_list[p*TW +: TW]`, and position 0 is the highest priority. A thread that is absent from the list ranks below every listed thread. A thread listed twice takes its first position.
- R4: Among entries of the same thread in the same bank, the earliest accepted entry is issued first.
- R5: In arrival mode (`arrival_order` = 1), each bank issues its earliest accepted entry, whatever its thread.
- R6: After an issue, `bank_busy` is high for max(`service_cycles`, 1) cycles, starting in the next cycle. `service_cycles` is sampled in the issue cycle. The bank issues nothing while busy, and can issue again in the first cycle after busy falls.
- R7: `thread_stall[t]` is high from the cycle after thread t's first outstanding request is accepted until the cycle after its last outstanding request finishes service.
- R8: `thread_done[t]` pulses for exactly one cycle, in the cycle where `thread_stall[t]` falls. During that pulse, `done_cycle` equals the number of rising clock edges since reset was released.
- R9: The ranking used for a decision is `rank_list` in any cycle where no bank is busy. Otherwise it is the value that was in use in the last such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_thread | input | TW | Thread of the request |
| req_bank | input | BW | Target bank of the request |
| req_ready | output | 1 | Target buffer can take the request |
| arrival_order | input | 1 | 1 = arrival order, 0 = ranked order |
| service_cycles | input | SVC_W | Service length in cycles (0 is treated as 1) |
| rank_list | input | NUM_THREADS*TW | Thread IDs in priority order, position 0 highest |
| issue_valid | output | NUM_BANKS | Bank starts a service this cycle |
| issue_thread | output | NUM_BANKS*TW | Thread being issued, one field per bank |
| bank_busy | output | NUM_BANKS | Bank is serving a request |
| thread_stall | output | NUM_THREADS | Thread has outstanding requests |
| thread_done | output | NUM_THREADS | One-cycle pulse when a thread's last request completes |
| done_cycle | output | CYC_W | Cycle count, valid with a done pulse |

## Verification
A buffer that loses or reorders an entry shows up in the next issue decision of that bank. The wrong thread appears on `issue_thread`, or `issue_valid` stays low, at most one service time later. A mistake in the outstanding count is different. It only becomes visible when the count should reach zero. At that point the stall bit and the done pulse are early, late or missing, so the bench compares both on every cycle. A ranking latched at the wrong moment matters only when `rank_list` changes during a service. For that reason one phase reshuffles the ranking on every cycle, and the comparison then catches a wrong pick at the next idle bank.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   typedef enum logic {
      BANK_IDLE  = 1'b0,
      BANK_SERVE = 1'b1
   } bank_state_e;
endpackage

// File: rtl/rbs_bank.sv
module rbs_bank
   import rbs_pkg::*;
#(
   parameter int NT    = 8,
   parameter int DEPTH = 8,
   parameter int SVC_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push,
   input  logic [$clog2(NT)-1:0] push_thread,
   output logic                full,
   input  logic                arrival,
   input  logic [NT*$clog2(NT)-1:0] rank_flat,
   input  logic [SVC_W-1:0]    svc_len,
   output logic                busy,
   output logic                issue,
   output logic [$clog2(NT)-1:0] issue_thread,
   output logic                fin,
   output logic [$clog2(NT)-1:0] fin_thread
);
   localparam int TW = $clog2(NT);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = $clog2(DEPTH);
   localparam int PW = $clog2(NT + 1);

   logic [TW-1:0] ent_q [DEPTH];
   logic [TW-1:0] ent_n [DEPTH];
   logic [CW-1:0] cnt_q, cnt_n, cnt_after;
   logic [PW-1:0] prio [DEPTH];
   logic [IW-1:0] sel_idx;

   bank_state_e   state_q;
   logic [SVC_W-1:0] rem_q;
   logic [TW-1:0] cur_q;

   // priority position of each stored entry; first listing wins
   for (genvar e = 0; e < DEPTH; e++) begin : g_prio
      always_comb begin
         prio[e] = PW'(NT);
         for (int p = NT - 1; p >= 0; p--) begin
            if (rank_flat[p*TW +: TW] == ent_q[e]) prio[e] = PW'(p);
         end
      end
   end

   // entry 0 is always the oldest, so the lowest index wins ties
   always_comb begin
      int best_p;
      best_p  = NT + 1;
      sel_idx = '0;
      if (!arrival) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < cnt_q && int'(prio[i]) < best_p) begin
               best_p  = int'(prio[i]);
               sel_idx = IW'(i);
            end
         end
      end
   end

   assign busy         = (state_q == BANK_SERVE);
   assign issue        = !busy && (cnt_q != '0);
   assign issue_thread = ent_q[sel_idx];
   assign full         = (cnt_q == CW'(DEPTH));
   assign fin          = busy && (rem_q == SVC_W'(1));
   assign fin_thread   = cur_q;

   // compacting buffer: remove the issued entry, then append
   always_comb begin
      for (int i = 0; i < DEPTH; i++) ent_n[i] = ent_q[i];
      if (issue) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            if (i >= int'(sel_idx)) ent_n[i] = ent_q[i+1];
         end
      end
      cnt_after = cnt_q - CW'(issue);
      if (push) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) == cnt_after) ent_n[i] = push_thread;
         end
      end
      cnt_n = cnt_after + CW'(push);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      end else begin
         cnt_q <= cnt_n;
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= BANK_IDLE;
         rem_q   <= '0;
         cur_q   <= '0;
      end else begin
         case (state_q)
            BANK_IDLE: if (issue) begin
               state_q <= BANK_SERVE;
               rem_q   <= (svc_len == '0) ? SVC_W'(1) : svc_len;
               cur_q   <= issue_thread;
            end
            default: begin
               if (rem_q == SVC_W'(1)) state_q <= BANK_IDLE;
               else                    rem_q   <= rem_q - SVC_W'(1);
            end
         endcase
      end
   end

   // R1: the top never pushes into a full buffer
   a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt_q < CW'(DEPTH)));
   // R6: a finishing service frees the bank in the next cycle
   a_r6_fin_frees: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !busy);
   // R2: an issue always starts a service
   a_r2_issue_starts: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> busy);
endmodule

// File: rtl/rbs_thread_track.sv
module rbs_thread_track #(
   parameter int NT    = 8,
   parameter int NB    = 4,
   parameter int MAXO  = 32,
   parameter int CYC_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc,
   input  logic [$clog2(NT)-1:0] acc_thread,
   input  logic [NB-1:0]         fin,
   input  logic [NB*$clog2(NT)-1:0] fin_thread_flat,
   output logic [NT-1:0]         stall,
   output logic [NT-1:0]         done,
   output logic [CYC_W-1:0]      cyc
);
   localparam int TW = $clog2(NT);
   localparam int OW = $clog2(MAXO + 1);

   logic [CYC_W-1:0] cyc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cyc_q <= '0;
      else        cyc_q <= cyc_q + CYC_W'(1);
   end
   assign cyc = cyc_q;

   for (genvar t = 0; t < NT; t++) begin : g_thr
      logic [OW-1:0] out_q, out_n;
      logic          inc;
      int            dec;
      logic          done_q;

      assign inc = acc && (acc_thread == TW'(t));

      always_comb begin
         dec = 0;
         for (int b = 0; b < NB; b++) begin
            if (fin[b] && fin_thread_flat[b*TW +: TW] == TW'(t)) dec = dec + 1;
         end
         out_n = out_q + OW'(inc) - OW'(dec);
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_q  <= '0;
            done_q <= 1'b0;
         end else begin
            out_q  <= out_n;
            done_q <= (out_q != '0) && (out_n == '0);
         end
      end

      assign stall[t] = (out_q != '0);
      assign done[t]  = done_q;

      // R7: completions never exceed what is outstanding
      a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
         dec <= int'(out_q) + int'(inc));
      // R8: a done pulse coincides with the stall bit falling
      a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
         done[t] |-> (!stall[t] && $past(stall[t])));
   end
endmodule

// File: rtl/rank_bank_sched.sv
module rank_bank_sched #(
   parameter int NUM_BANKS   = 4,
   parameter int NUM_THREADS = 8,
   parameter int QDEPTH      = 8,
   parameter int SVC_W       = 8,
   parameter int CYC_W       = 16,
   parameter int TW          = $clog2(NUM_THREADS),
   parameter int BW          = $clog2(NUM_BANKS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [TW-1:0]             req_thread,
   input  logic [BW-1:0]             req_bank,
   output logic                      req_ready,
   input  logic                      arrival_order,
   input  logic [SVC_W-1:0]          service_cycles,
   input  logic [NUM_THREADS*TW-1:0] rank_list,
   output logic [NUM_BANKS-1:0]      issue_valid,
   output logic [NUM_BANKS*TW-1:0]   issue_thread,
   output logic [NUM_BANKS-1:0]      bank_busy,
   output logic [NUM_THREADS-1:0]    thread_stall,
   output logic [NUM_THREADS-1:0]    thread_done,
   output logic [CYC_W-1:0]          done_cycle
);
   localparam int MAXO = NUM_BANKS * QDEPTH;

   if (NUM_BANKS < 2)  begin : g_bad_banks   $error("NUM_BANKS must be at least 2"); end
   if (NUM_THREADS < 2 || (1 << TW) != NUM_THREADS)
                       begin : g_bad_threads $error("NUM_THREADS must be a power of two >= 2"); end
   if (QDEPTH < 2)     begin : g_bad_depth   $error("QDEPTH must be at least 2"); end
   if (SVC_W < 1)      begin : g_bad_svc     $error("SVC_W must be at least 1"); end
   if (CYC_W < 2)      begin : g_bad_cyc     $error("CYC_W must be at least 2"); end

   logic [NUM_BANKS-1:0]      full, push, fin;
   logic [NUM_BANKS*TW-1:0]   fin_thread;
   logic [NUM_THREADS*TW-1:0] rank_q, rank_eff;
   logic                      all_idle, bank_ok;

   assign bank_ok   = (int'(req_bank) < NUM_BANKS);
   assign req_ready = bank_ok && !full[req_bank];
   assign all_idle  = (bank_busy == '0);
   assign rank_eff  = all_idle ? rank_list : rank_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_THREADS; p++) rank_q[p*TW +: TW] <= TW'(p);
      end else begin
         rank_q <= rank_eff;
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign push[b] = req_valid && req_ready && (req_bank == BW'(b));

      rbs_bank #(
         .NT    (NUM_THREADS),
         .DEPTH (QDEPTH),
         .SVC_W (SVC_W)
      ) u_bank (
         .clk          (clk),
         .rst_n        (rst_n),
         .push         (push[b]),
         .push_thread  (req_thread),
         .full         (full[b]),
         .arrival      (arrival_order),
         .rank_flat    (rank_eff),
         .svc_len      (service_cycles),
         .busy         (bank_busy[b]),
         .issue        (issue_valid[b]),
         .issue_thread (issue_thread[b*TW +: TW]),
         .fin          (fin[b]),
         .fin_thread   (fin_thread[b*TW +: TW])
      );
   end

   rbs_thread_track #(
      .NT    (NUM_THREADS),
      .NB    (NUM_BANKS),
      .MAXO  (MAXO),
      .CYC_W (CYC_W)
   ) u_track (
      .clk             (clk),
      .rst_n           (rst_n),
      .acc             (req_valid && req_ready),
      .acc_thread      (req_thread),
      .fin             (fin),
      .fin_thread_flat (fin_thread),
      .stall           (thread_stall),
      .done            (thread_done),
      .cyc             (done_cycle)
   );

   // R9: the ranking in use cannot move while any bank is serving
   a_r9_rank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (|bank_busy) |-> (rank_eff == $past(rank_eff)));
   // R1: nothing is accepted for a bank whose buffer is full
   a_r1_refuse_full: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && bank_ok && full[req_bank]) |-> !req_ready);
endmodule

// File: tb/rank_bank_sched_test.sv
module rank_bank_sched_test;
   localparam int NB = 4;
   localparam int NT = 8;
   localparam int QD = 8;
   localparam int TW = 3;
   localparam int BW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [TW-1:0] req_thread = '0;
   logic [BW-1:0] req_bank = '0;
   logic req_ready;
   logic arrival_order = 1'b0;
   logic [7:0] service_cycles = 8'd3;
   logic [NT*TW-1:0] rank_list = '0;
   logic [NB-1:0] issue_valid;
   logic [NB*TW-1:0] issue_thread;
   logic [NB-1:0] bank_busy;
   logic [NT-1:0] thread_stall;
   logic [NT-1:0] thread_done;
   logic [15:0] done_cycle;

   always #10 clk = ~clk;

   rank_bank_sched uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_thread(req_thread),
      .req_bank(req_bank), .req_ready(req_ready), .arrival_order(arrival_order),
      .service_cycles(service_cycles), .rank_list(rank_list),
      .issue_valid(issue_valid), .issue_thread(issue_thread), .bank_busy(bank_busy),
      .thread_stall(thread_stall), .thread_done(thread_done), .done_cycle(done_cycle)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // behavioural reference
   int m_q [NB][$];
   bit m_busy [NB];
   int m_rem [NB];
   int m_cur [NB];
   int m_out [NT];
   bit m_done [NT];
   int m_rank [NT];
   int m_cyc = 0;
   int rk [NT];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, m_cyc);
      end
   endtask

   function automatic int prio_of(input int th, input int re[NT]);
      for (int p = 0; p < NT; p++) if (re[p] == th) return p;
      return NT;
   endfunction

   task automatic step(input bit v, input int th, input int bk);
      int re [NT];
      bit idle;
      bit iss [NB];
      int sel [NB];
      int new_out [NT];
      bit acc;
      bit any_done;
      int svc;
      req_valid  = v;
      req_thread = TW'(th);
      req_bank   = BW'(bk);
      for (int p = 0; p < NT; p++) rank_list[p*TW +: TW] = TW'(rk[p]);
      #1;
      idle = 1'b1;
      for (int b = 0; b < NB; b++) if (m_busy[b]) idle = 1'b0;
      for (int p = 0; p < NT; p++) re[p] = idle ? rk[p] : m_rank[p];
      acc = v && (m_q[bk].size() < QD);
      if (v) chk(req_ready == acc, "R1 req_ready", int'(req_ready), int'(acc));
      for (int b = 0; b < NB; b++) begin
         iss[b] = !m_busy[b] && (m_q[b].size() > 0);
         sel[b] = 0;
         if (iss[b] && !arrival_order) begin
            int best;
            best = NT + 1;
            // R4: strict less-than keeps the oldest of equal rank
            for (int i = 0; i < m_q[b].size(); i++) begin
               if (prio_of(m_q[b][i], re) < best) begin
                  best = prio_of(m_q[b][i], re);
                  sel[b] = i;
               end
            end
         end
         chk(issue_valid[b] == iss[b], "R2 issue_valid", int'(issue_valid[b]), int'(iss[b]));
         if (iss[b]) begin
            int got;
            got = int'(issue_thread[b*TW +: TW]);
            chk(got == m_q[b][sel[b]], arrival_order ? "R5 arrival pick" :
                (idle ? "R3 R4 ranked pick" : "R9 held ranking pick"), got, m_q[b][sel[b]]);
         end
         chk(bank_busy[b] == m_busy[b], "R6 bank_busy", int'(bank_busy[b]), int'(m_busy[b]));
      end
      any_done = 1'b0;
      for (int t = 0; t < NT; t++) begin
         chk(thread_stall[t] == (m_out[t] != 0), "R7 thread_stall", int'(thread_stall[t]),
             int'(m_out[t] != 0));
         chk(thread_done[t] == m_done[t], "R8 thread_done", int'(thread_done[t]), int'(m_done[t]));
         if (m_done[t]) any_done = 1'b1;
      end
      if (any_done) chk(int'(done_cycle) == (m_cyc & 16'hffff), "R8 done_cycle",
                        int'(done_cycle), m_cyc & 16'hffff);
      // advance the model by one clock
      for (int t = 0; t < NT; t++) new_out[t] = m_out[t];
      if (acc) new_out[th]++;
      svc = (service_cycles == 0) ? 1 : int'(service_cycles);
      for (int b = 0; b < NB; b++) begin
         if (m_busy[b]) begin
            if (m_rem[b] == 1) begin
               new_out[m_cur[b]]--;
               m_busy[b] = 1'b0;
            end else begin
               m_rem[b]--;
            end
         end else if (iss[b]) begin
            m_cur[b] = m_q[b][sel[b]];
            m_q[b].delete(sel[b]);
            m_busy[b] = 1'b1;
            m_rem[b] = svc;
         end
      end
      if (acc) m_q[bk].push_back(th);
      for (int t = 0; t < NT; t++) begin
         m_done[t] = (m_out[t] != 0) && (new_out[t] == 0);
         m_out[t] = new_out[t];
      end
      for (int p = 0; p < NT; p++) m_rank[p] = re[p];
      m_cyc++;
      @(negedge clk);
   endtask

   task automatic idle_steps(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 0, 0);
   endtask

   task automatic shuffle_rank();
      for (int p = 0; p < NT; p++) rk[p] = p;
      for (int p = NT - 1; p > 0; p--) begin
         int j, tmp;
         j = $urandom_range(p, 0);
         tmp = rk[p]; rk[p] = rk[j]; rk[j] = tmp;
      end
   endtask

   task automatic rand_steps(input int n, input bit reshuffle, input bit vary_svc);
      for (int i = 0; i < n; i++) begin
         if (reshuffle) shuffle_rank();
         if (vary_svc && (i % 50 == 0)) service_cycles = 8'($urandom_range(4, 0));
         step($urandom_range(99, 0) < 60, $urandom_range(NT - 1, 0), $urandom_range(NB - 1, 0));
      end
   endtask

   initial begin
      for (int p = 0; p < NT; p++) begin rk[p] = p; m_rank[p] = p; end
      for (int t = 0; t < NT; t++) begin m_out[t] = 0; m_done[t] = 1'b0; end
      for (int b = 0; b < NB; b++) begin m_busy[b] = 1'b0; m_rem[b] = 0; m_cur[b] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state: nothing stalled, busy or issuing
      idle_steps(2);

      // ranked order with repeated threads in one bank (R3, R4)
      rk = '{5, 3, 1, 0, 2, 4, 6, 7};
      service_cycles = 8'd3;
      step(1'b1, 3, 0); step(1'b1, 1, 0); step(1'b1, 3, 0); step(1'b1, 5, 0);
      step(1'b1, 1, 1); step(1'b1, 2, 1); step(1'b1, 5, 1);
      idle_steps(30);

      // fill one bank past its depth during a long service (R1)
      service_cycles = 8'd20;
      for (int i = 0; i < 11; i++) step(1'b1, i % NT, 2);
      idle_steps(260);

      // arrival order under random traffic (R5)
      arrival_order = 1'b1;
      service_cycles = 8'd2;
      rand_steps(600, 1'b0, 1'b0);
      idle_steps(150);

      // ranking reshuffled every cycle, service length varied incl. zero (R6, R9)
      arrival_order = 1'b0;
      rand_steps(1500, 1'b1, 1'b1);
      idle_steps(300);

      // ranking with repeats and missing threads (R3)
      rk = '{2, 2, 6, 6, 0, 0, 0, 0};
      service_cycles = 8'd1;
      rand_steps(300, 1'b0, 1'b0);
      idle_steps(150);

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule